// File: doc/BRIEF.md
# Crosspoint Route Controller

This block is the control logic for a routing matrix with eight inputs and four outputs. Each output has a staged route slot and a live route slot. A host writes route codes into the staged slots one at a time through a parallel strobe interface. One global commit strobe then moves every staged code into the live slots in the same clock cycle, so all changed routes switch together. Several of these blocks can therefore be preloaded one after another and then updated by a single shared commit.

The live slots drive a one-hot switch-enable row for each output and an active-low disable flag for each output. A route-clear input empties the live slots and leaves the staged slots unchanged, so a later commit brings back the routing that was in place before the clear.

The host can read the live route codes back over the shared input-select bus. The design is synchronous. Every host strobe passes through a two-flop synchronizer, and the block acts on the edges it detects.

Top module: `xpoint_route_ctl`

## Requirements
- R1: A route code is 4 bits. When bit 3 is 1 the output is connected, and bits 2:0 select input 0 to 7. Switch-enable row `o` is bits `o*8+7 : o*8` of `switchEn`. In that row, bit `code[2:0]` is set when the output is connected. The whole row is zero when bit 3 is 0.
- R2: A write strobe rise (`wrN` going low and then high) stores `inSelIn` into the staged slot chosen by `outSel`, when `selN`=0, `dirRead`=0, `clrN`=1 and `commitN`=1. The switch enables do not change until a commit.
- R3: A falling edge on `commitN` copies all four staged slots into the live slots in the same cycle.
- R4: While `clrN` is low, every live slot is off. The staged slots keep their contents, and a commit after `clrN` returns high restores them.
- R5: When `selN`=0, `dirRead`=1 and `wrN`=1, `inSelOe` is 1 and `inSelOut` carries the live code of the slot chosen by `outSel`.
- R6: While `selN` is high, `inSelOe` is 0 and write strobes leave the staged slots unchanged.
- R7: `disableN[o]` is 0 whenever live slot `o` is off or `clrN` is low, and 1 otherwise.
- R8: Power-on reset (`rstN` low) sets both the staged and the live slots to off.
- R9: A write strobe is ignored when `dirRead` is 1 or when `clrN` is low.
- R10: If a commit falling edge and a route clear reach the block in the same cycle, the clear wins and every live slot ends up off.
- R11: Each switch-enable row has at most one bit set. Any number of rows may select the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| selN | input | 1 | Chip select, active low |
| dirRead | input | 1 | Bus direction: 1 = read back, 0 = write |
| wrN | input | 1 | Write strobe, active low; the rising edge stores the code |
| commitN | input | 1 | Global commit strobe; the falling edge copies staged to live |
| clrN | input | 1 | Route clear, active low; empties the live slots |
| inSelIn | input | 4 | Route code driven by the host on the shared bus |
| outSel | input | 2 | Output slot select |
| inSelOut | output | 4 | Readback route code |
| inSelOe | output | 1 | Drive enable for the shared bus |
| switchEn | output | 32 | Four one-hot rows of eight switch enables |
| disableN | output | 4 | Per-output disable flags, active low |

## Verification
Two actions can land in the same cycle: a commit falling edge and a route clear. The bench provokes this by driving `commitN` and `clrN` low in the same step. Both pass through synchronizers of equal depth, so they reach the datapath together. The result is judged on the switch enables, the disable flags and the readback, which must all show every output off. A later commit, issued after the clear is released, must bring back the staged routing.

// File: rtl/xrc_pkg.sv
package xrc_pkg;
  // Single-cycle actions handed from control to datapath
  typedef struct packed {
    logic wrCapture;  // qualified write strobe rise
    logic commit;     // commit strobe fall
    logic clear;      // route clear level
    logic readEn;     // readback window open
  } xrcStrobes_t;
endpackage

// File: rtl/xrc_ctrl.sv
module xrc_ctrl
  import xrc_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selN,
  input  logic        dirRead,
  input  logic        wrN,
  input  logic        commitN,
  input  logic        clrN,
  output xrcStrobes_t strobes
);
  localparam int N_CTL = 5;
  localparam int B_SEL = 0;
  localparam int B_DIR = 1;
  localparam int B_WR  = 2;
  localparam int B_CMT = 3;
  localparam int B_CLR = 4;
  localparam logic [N_CTL-1:0] IDLE_VAL = 5'b11101;

  logic [N_CTL-1:0] raw;
  logic [N_CTL-1:0] pipe [SYNC_DEPTH+1];
  logic [N_CTL-1:0] cur;
  logic [N_CTL-1:0] prev;

  assign raw = {clrN, commitN, wrN, dirRead, selN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= SYNC_DEPTH; i++) pipe[i] <= IDLE_VAL;
    end else begin
      pipe[0] <= raw;
      for (int i = 1; i <= SYNC_DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign cur  = pipe[SYNC_DEPTH-1];
  assign prev = pipe[SYNC_DEPTH];

  always_comb begin
    strobes.wrCapture = cur[B_WR] & ~prev[B_WR] & ~cur[B_SEL] & ~cur[B_DIR]
                        & cur[B_CLR] & cur[B_CMT];
    strobes.commit    = ~cur[B_CMT] & prev[B_CMT];
    strobes.clear     = ~cur[B_CLR];
    strobes.readEn    = ~cur[B_SEL] & cur[B_DIR] & cur[B_WR];
  end
endmodule

// File: rtl/xrc_datapath.sv
module xrc_datapath
  import xrc_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 4,
  localparam int IN_W   = $clog2(NUM_IN),
  localparam int CODE_W = IN_W + 1,
  localparam int OUT_W  = $clog2(NUM_OUT)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  xrcStrobes_t               strobes,
  input  logic [CODE_W-1:0]         codeIn,
  input  logic [OUT_W-1:0]          slotSel,
  output logic [CODE_W-1:0]         codeOut,
  output logic                      codeOe,
  output logic [NUM_OUT*NUM_IN-1:0] switchEn,
  output logic [NUM_OUT-1:0]        disableN
);
  localparam int ON_BIT = CODE_W - 1;

  logic [CODE_W-1:0] staged [NUM_OUT];
  logic [CODE_W-1:0] live   [NUM_OUT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int o = 0; o < NUM_OUT; o++) begin
        staged[o] <= '0;
        live[o]   <= '0;
      end
    end else begin
      if (strobes.wrCapture) staged[slotSel] <= codeIn;
      if (strobes.clear) begin
        for (int o = 0; o < NUM_OUT; o++) live[o] <= '0;
      end else if (strobes.commit) begin
        for (int o = 0; o < NUM_OUT; o++) live[o] <= staged[o];
      end
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_row
    for (genvar i = 0; i < NUM_IN; i++) begin : g_col
      assign switchEn[o*NUM_IN+i] = live[o][ON_BIT] && (live[o][IN_W-1:0] == IN_W'(i));
    end
    assign disableN[o] = live[o][ON_BIT] & ~strobes.clear;
  end

  assign codeOut = live[slotSel];
  assign codeOe  = strobes.readEn;
endmodule

// File: rtl/xpoint_route_ctl.sv
module xpoint_route_ctl
  import xrc_pkg::*;
#(
  parameter int NUM_IN     = 8,
  parameter int NUM_OUT    = 4,
  parameter int SYNC_DEPTH = 2,
  localparam int CODE_W    = $clog2(NUM_IN) + 1,
  localparam int OUT_W     = $clog2(NUM_OUT)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      selN,
  input  logic                      dirRead,
  input  logic                      wrN,
  input  logic                      commitN,
  input  logic                      clrN,
  input  logic [CODE_W-1:0]         inSelIn,
  input  logic [OUT_W-1:0]          outSel,
  output logic [CODE_W-1:0]         inSelOut,
  output logic                      inSelOe,
  output logic [NUM_OUT*NUM_IN-1:0] switchEn,
  output logic [NUM_OUT-1:0]        disableN
);
  xrcStrobes_t strobes;

  xrc_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .dirRead(dirRead), .wrN(wrN),
    .commitN(commitN), .clrN(clrN), .strobes(strobes)
  );

  xrc_datapath #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .codeIn(inSelIn),
    .slotSel(outSel), .codeOut(inSelOut), .codeOe(inSelOe),
    .switchEn(switchEn), .disableN(disableN)
  );
endmodule

// File: rtl/xrc_chk.sv
module xrc_chk
  import xrc_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 4,
  localparam int CODE_W = $clog2(NUM_IN) + 1,
  localparam int OUT_W  = $clog2(NUM_OUT)
) (
  input logic                      clk,
  input logic                      rstN,
  input xrcStrobes_t               strobes,
  input logic [CODE_W-1:0]         inSelOut,
  input logic                      inSelOe,
  input logic [OUT_W-1:0]          outSel,
  input logic [NUM_OUT*NUM_IN-1:0] switchEn,
  input logic [NUM_OUT-1:0]        disableN
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
    // R11
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(switchEn[o*NUM_IN +: NUM_IN]));
    // R7
    flag_needs_route_chk: assert property (@(posedge clk) disable iff (!rstN)
      disableN[o] |-> (|switchEn[o*NUM_IN +: NUM_IN]));
  end

  // R3
  live_change_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(switchEn) |-> $past(strobes.commit || strobes.clear));

  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (switchEn == '0));

  // R5
  readback_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    inSelOe |-> (inSelOut[CODE_W-1] == (|switchEn[outSel*NUM_IN +: NUM_IN])));
endmodule

bind xpoint_route_ctl xrc_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .inSelOut(inSelOut),
  .inSelOe(inSelOe), .outSel(outSel), .switchEn(switchEn), .disableN(disableN)
);

// File: tb/sim_xpoint_route_ctl.sv
`timescale 1ns/1ps
module sim_xpoint_route_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, dirRead = 1'b0, wrN = 1'b1, commitN = 1'b1, clrN = 1'b1;
  logic [3:0] inSelIn = '0;
  logic [1:0] outSel = '0;
  logic [3:0] inSelOut;
  logic inSelOe;
  logic [31:0] switchEn;
  logic [3:0] disableN;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xpoint_route_ctl u0 (
    .clk(clk), .rstN(rstN), .selN(selN), .dirRead(dirRead), .wrN(wrN),
    .commitN(commitN), .clrN(clrN), .inSelIn(inSelIn), .outSel(outSel),
    .inSelOut(inSelOut), .inSelOe(inSelOe), .switchEn(switchEn), .disableN(disableN)
  );

  function automatic logic [7:0] rowOf(input logic [3:0] code);
    return code[3] ? (8'b1 << code[2:0]) : 8'h00;
  endfunction

  function automatic logic [31:0] matOf(input logic [3:0] c0, c1, c2, c3);
    return {rowOf(c3), rowOf(c2), rowOf(c1), rowOf(c0)};
  endfunction

  function automatic logic [3:0] flagsOf(input logic [3:0] c0, c1, c2, c3);
    return {c3[3], c2[3], c1[3], c0[3]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic writeSlot(input logic [1:0] o, input logic [3:0] code,
                           input logic sel, input logic dir);
    selN = sel; dirRead = dir; outSel = o; inSelIn = code; wrN = 1'b0;
    settle();
    wrN = 1'b1;
    settle();
    selN = 1'b1; dirRead = 1'b0;
    settle();
  endtask

  task automatic commit();
    commitN = 1'b0; settle();
    commitN = 1'b1; settle();
  endtask

  task automatic powerReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
  endtask

  task automatic tReset();
    powerReset();
    check("R8 reset switchEn", switchEn, 32'h0);
    check("R7 reset flags", {28'h0, disableN}, 32'h0);
    check("R6 reset oe", {31'h0, inSelOe}, 32'h0);
  endtask

  task automatic tStageCommit();
    writeSlot(2'd0, 4'b1010, 1'b0, 1'b0);
    writeSlot(2'd1, 4'b1111, 1'b0, 1'b0);
    writeSlot(2'd2, 4'b0101, 1'b0, 1'b0);
    writeSlot(2'd3, 4'b1010, 1'b0, 1'b0);
    check("R2 staged not live", switchEn, 32'h0);
    commit();
    check("R3 R1 R11 commit all", switchEn, matOf(4'b1010, 4'b1111, 4'b0101, 4'b1010));
    check("R7 flags", {28'h0, disableN}, {28'h0, 4'b1011});
    writeSlot(2'd0, 4'b1000, 1'b0, 1'b0);
    check("R2 live holds", switchEn, matOf(4'b1010, 4'b1111, 4'b0101, 4'b1010));
    commit();
    check("R3 second commit", switchEn, matOf(4'b1000, 4'b1111, 4'b0101, 4'b1010));
  endtask

  task automatic tReadback();
    logic [3:0] exp [4] = '{4'b1000, 4'b1111, 4'b0101, 4'b1010};
    selN = 1'b0; dirRead = 1'b1; wrN = 1'b1;
    settle();
    for (int o = 0; o < 4; o++) begin
      outSel = 2'(o);
      @(negedge clk);
      check("R5 oe", {31'h0, inSelOe}, 32'h1);
      check("R5 code", {28'h0, inSelOut}, {28'h0, exp[o]});
    end
    selN = 1'b1;
    settle();
    check("R6 oe off", {31'h0, inSelOe}, 32'h0);
    dirRead = 1'b0;
    settle();
  endtask

  task automatic tIgnored();
    writeSlot(2'd0, 4'b1001, 1'b1, 1'b0);
    writeSlot(2'd1, 4'b1001, 1'b0, 1'b1);
    commit();
    check("R6 R9 writes ignored", switchEn, matOf(4'b1000, 4'b1111, 4'b0101, 4'b1010));
  endtask

  task automatic tClear();
    clrN = 1'b0; settle();
    check("R4 clear", switchEn, 32'h0);
    check("R7 clear flags", {28'h0, disableN}, 32'h0);
    writeSlot(2'd3, 4'b1001, 1'b0, 1'b0);
    commit();
    check("R4 commit during clear", switchEn, 32'h0);
    clrN = 1'b1; settle();
    commit();
    check("R4 R9 restore", switchEn, matOf(4'b1000, 4'b1111, 4'b0101, 4'b1010));
  endtask

  task automatic tSameCycle();
    clrN = 1'b0; commitN = 1'b0;
    settle();
    check("R10 clear wins", switchEn, 32'h0);
    clrN = 1'b1; settle();
    check("R10 no late commit", switchEn, 32'h0);
    commitN = 1'b1; settle();
    commit();
    check("R10 restore after", switchEn, matOf(4'b1000, 4'b1111, 4'b0101, 4'b1010));
  endtask

  task automatic tPorStaged();
    powerReset();
    commit();
    check("R8 staged cleared", switchEn, 32'h0);
    check("R8 flags", {28'h0, disableN}, 32'h0);
  endtask

  initial begin
    tReset();
    tStageCommit();
    tReadback();
    tIgnored();
    tClear();
    tSameCycle();
    tPorStaged();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule